// File: doc/BRIEF.md
# Long-Period Linear Recurrence Generator Core

This core produces one 32-bit pseudo-random word on every clock while it runs. It uses a linear recurrence over GF(2) with a state of 19937 effective bits. The state is 624 words of 32 bits. Only the top bit of the oldest word takes part, so the 31 low bits of that word carry no information. Each step reads six state words at fixed logical offsets. It mixes them with shifts, masks and XOR into two new words. The second new word becomes the newest state word and, after an output tempering stage, the sample. The first new word becomes the next-newest state word.

Software or a neighbouring block first fills the state through a seed port, one word per beat, while the run input is low. Raising run then yields a sample per cycle. Lowering run freezes the state, and raising it again continues the same sequence. Loading a fresh set of words after a completed seed starts a new sequence from the new contents.

Top module: `well_gen_core`

## Requirements
- R1: After reset, rnd_valid and rnd_data are 0 and the core counts as unseeded.
- R2: While run is low, a seed beat (seed_valid high, seed_index < R) writes seed_word into logical state word seed_index, where word 0 is the newest. The first beat after reset, or after a completed seed, starts a new seed and a new sequence.
- R3: rnd_valid stays low until R accepted seed beats of the current seed have been taken, whatever run does.
- R4: With logical words V, a step computes z0 = (V[R-1] & 0x80000000) | (V[R-2] & 0x7FFFFFFF), z1 = V[0]^(V[0]<<25)^V[M1]^(V[M1]>>27), z2 = (V[M2]>>9)^V[M3]^(V[M3]>>1), f1 = z1^z2 and f2 = z0^(z0<<9)^z1^(z1<<21)^z2^(z2>>21)^f1. Afterwards V[0] is f2, V[1] is f1 and each old V[i] for 1 <= i <= R-2 moves to V[i+1].
- R5: The sample is f2 tempered as y ^= (y<<7) & 0xE46E1700, then y ^= (y<<15) & 0x9B868000.
- R6: In the cycle after each clock edge at which run is high and the seed is complete, rnd_valid is 1 and rnd_data holds that step's sample. Steps run back to back at one per cycle.
- R7: An edge with run low performs no step and the state is held. rnd_valid is 0 in the following cycle, and resuming continues the sequence unchanged.
- R8: Seed beats presented while run is high are ignored.
- R9: Seed beats with seed_index >= R are ignored and do not count toward the R beats.
- R10: The sequence remains correct over more than R consecutive steps, across the wrap of the circular state storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | High: step once per cycle when seeded; low: hold |
| seed_valid | input | 1 | Seed beat strobe |
| seed_index | input | $clog2(R) | Logical state word written by the beat |
| seed_word | input | 32 | Data for the seed beat |
| rnd_valid | output | 1 | A new sample is on rnd_data |
| rnd_data | output | 32 | Tempered sample |

## Verification
The bench builds the core with its default size of 624 words and tap offsets 70, 179 and 449, so the real recurrence is compared against an independent model that shifts a plain array. More than 624 back-to-back steps are run on one seed, which walks the circular pointer through a full wrap and beyond. The bench also checks a partial seed, out-of-range and run-time seed beats, isolated single steps between pauses and a full reseed.

// File: rtl/well_pkg.sv
package well_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t MSB_MASK  = 32'h8000_0000;
    localparam word_t LSB_MASK  = ~MSB_MASK;
    localparam word_t TMASK_ONE = 32'hE46E_1700;
    localparam word_t TMASK_TWO = 32'h9B86_8000;

    localparam int SH_HEAD = 25;
    localparam int SH_M1   = 27;
    localparam int SH_M2   = 9;
    localparam int SH_M3   = 1;
    localparam int SH_Z0   = 9;
    localparam int SH_Z1   = 21;
    localparam int SH_Z2   = 21;
    localparam int SH_T1   = 7;
    localparam int SH_T2   = 15;
endpackage

// File: rtl/well_state_ram.sv
module well_state_ram
    import well_pkg::*;
#(
    parameter int DEPTH = 624,
    parameter int NRD   = 5,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  word_t                   wr_data,
    input  logic [NRD-1:0][AW-1:0]  rd_addr,
    output word_t [NRD-1:0]         rd_data
);
    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = mem_q[rd_addr[g]];
    end
endmodule

// File: rtl/well_mix.sv
module well_mix
    import well_pkg::*;
(
    input  word_t tap_head,
    input  word_t tap_m1,
    input  word_t tap_m2,
    input  word_t tap_m3,
    input  word_t tap_pen,
    input  word_t tap_last,
    output word_t fb_one,
    output word_t fb_two
);
    word_t z0, z1, z2;

    always_comb begin
        z0     = (tap_last & MSB_MASK) | (tap_pen & LSB_MASK);
        z1     = (tap_head ^ (tap_head << SH_HEAD)) ^ (tap_m1 ^ (tap_m1 >> SH_M1));
        z2     = (tap_m2 >> SH_M2) ^ (tap_m3 ^ (tap_m3 >> SH_M3));
        fb_one = z1 ^ z2;
        fb_two = (z0 ^ (z0 << SH_Z0)) ^ (z1 ^ (z1 << SH_Z1)) ^ (z2 ^ (z2 >> SH_Z2)) ^ fb_one;
    end
endmodule

// File: rtl/well_temper.sv
module well_temper
    import well_pkg::*;
(
    input  word_t raw,
    output word_t tempered
);
    word_t mid;

    always_comb begin
        mid      = raw ^ ((raw << SH_T1) & TMASK_ONE);
        tempered = mid ^ ((mid << SH_T2) & TMASK_TWO);
    end

    // R5: both stages only mix in bits shifted left by 7 or more
    always_comb begin
        p_temper_low_r5: assert (tempered[SH_T1-1:0] == raw[SH_T1-1:0]);
    end
endmodule

// File: rtl/well_gen_core.sv
module well_gen_core
    import well_pkg::*;
#(
    parameter int R  = 624,
    parameter int M1 = 70,
    parameter int M2 = 179,
    parameter int M3 = 449,
    localparam int AW = $clog2(R),
    localparam int CW = $clog2(R + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          seed_valid,
    input  logic [AW-1:0] seed_index,
    input  logic [31:0]   seed_word,
    output logic          rnd_valid,
    output logic [31:0]   rnd_data
);
    localparam int NRD = 5;

    typedef struct packed {
        logic [AW-1:0] base;
        word_t         head;
        logic [CW-1:0] cnt;
        logic          ov;
        word_t         od;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic                   wr_en;
    logic [AW-1:0]          wr_addr;
    word_t                  wr_data;
    logic [NRD-1:0][AW-1:0] rd_addr;
    word_t [NRD-1:0]        rd_data;
    word_t                  fb_one, fb_two, smp;
    logic                   seeded, step, seed_ok;

    function automatic logic [AW-1:0] phys(input logic [AW-1:0] b, input int off);
        int s;
        s = int'(b) + off;
        if (s >= R) s = s - R;
        return AW'(s);
    endfunction

    always_comb begin
        rd_addr[0] = phys(ctl_q.base, M1);
        rd_addr[1] = phys(ctl_q.base, M2);
        rd_addr[2] = phys(ctl_q.base, M3);
        rd_addr[3] = phys(ctl_q.base, R - 2);
        rd_addr[4] = phys(ctl_q.base, R - 1);
    end

    well_state_ram #(.DEPTH(R), .NRD(NRD)) u_ram (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    well_mix u_mix (
        .tap_head(ctl_q.head),
        .tap_m1  (rd_data[0]),
        .tap_m2  (rd_data[1]),
        .tap_m3  (rd_data[2]),
        .tap_pen (rd_data[3]),
        .tap_last(rd_data[4]),
        .fb_one  (fb_one),
        .fb_two  (fb_two)
    );

    well_temper u_temper (
        .raw     (fb_two),
        .tempered(smp)
    );

    always_comb begin
        seeded  = (ctl_q.cnt == CW'(R));
        step    = run && seeded;
        seed_ok = seed_valid && !run && (int'(seed_index) < R);
        ctl_d    = ctl_q;
        ctl_d.ov = 1'b0;
        wr_en    = 1'b0;
        wr_addr  = ctl_q.base;
        wr_data  = fb_one;
        if (seed_ok) begin
            ctl_d.base = '0;
            ctl_d.cnt  = seeded ? CW'(1) : ctl_q.cnt + CW'(1);
            if (seed_index == '0) begin
                ctl_d.head = seed_word;
            end else begin
                wr_en   = 1'b1;
                wr_addr = seed_index;
                wr_data = seed_word;
            end
        end else if (step) begin
            wr_en      = 1'b1;
            ctl_d.head = fb_two;
            ctl_d.base = (ctl_q.base == '0) ? AW'(R - 1) : ctl_q.base - AW'(1);
            ctl_d.ov   = 1'b1;
            ctl_d.od   = smp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rnd_valid = ctl_q.ov;
    assign rnd_data  = ctl_q.od;

    p_valid_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |-> $past(run));
    p_full_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && seeded) |=> rnd_valid);
    p_quiet_unseeded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !seeded |=> !rnd_valid);
    p_hold_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !seed_valid) |=> ($stable(ctl_q.base) && $stable(ctl_q.head) && !rnd_valid));
    p_base_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ctl_q.base) < R);
endmodule

// File: tb/tb_well_gen_core.sv
module tb_well_gen_core;
    localparam int R  = 624;
    localparam int M1 = 70;
    localparam int M2 = 179;
    localparam int M3 = 449;
    localparam int IW = $clog2(R);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          seed_valid = 1'b0;
    logic [IW-1:0] seed_index = '0;
    logic [31:0]   seed_word = '0;
    logic          rnd_valid;
    logic [31:0]   rnd_data;

    well_gen_core #(.R(R), .M1(M1), .M2(M2), .M3(M3)) dut (
        .clk(clk), .rst_n(rst_n), .run(run), .seed_valid(seed_valid),
        .seed_index(seed_index), .seed_word(seed_word),
        .rnd_valid(rnd_valid), .rnd_data(rnd_data)
    );

    always #10 clk = ~clk;

    int          n_checks = 0;
    int          n_errs   = 0;
    int          n_match  = 0;
    int          cycles   = 0;
    bit          done     = 1'b0;
    string       cur_tag  = "R6";
    logic [31:0] exp_q[$];
    logic [31:0] mref [R];
    int          mcnt = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] temper(input logic [31:0] y);
        logic [31:0] t;
        t = y ^ ((y << 7) & 32'hE46E1700);
        t = t ^ ((t << 15) & 32'h9B868000);
        return t;
    endfunction

    // R4 reference: explicit shift of a plain array
    task automatic model_step;
        logic [31:0] z0, z1, z2, f1, f2;
        z0 = (mref[R-1] & 32'h80000000) | (mref[R-2] & 32'h7FFFFFFF);
        z1 = mref[0] ^ (mref[0] << 25) ^ mref[M1] ^ (mref[M1] >> 27);
        z2 = (mref[M2] >> 9) ^ mref[M3] ^ (mref[M3] >> 1);
        f1 = z1 ^ z2;
        f2 = z0 ^ (z0 << 9) ^ z1 ^ (z1 << 21) ^ z2 ^ (z2 >> 21) ^ f1;
        for (int i = R - 1; i >= 2; i--) mref[i] = mref[i-1];
        mref[1] = f1;
        mref[0] = f2;
        exp_q.push_back(temper(f2));
    endtask

    task automatic load_word(input int idx, input logic [31:0] d);
        seed_valid = 1'b1;
        seed_index = idx[IW-1:0];
        seed_word  = d;
        tick();
        seed_valid = 1'b0;
        if (!run && idx < R) begin
            mcnt = (mcnt == R) ? 1 : mcnt + 1;
            mref[idx] = d;
        end
    endtask

    task automatic run_steps(input int n, input bit noisy);
        run = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (noisy) begin
                seed_valid = 1'b1;
                seed_index = IW'((k * 37) % R);
                seed_word  = 32'hDEAD0000 ^ k;
            end
            tick();
            if (mcnt == R) model_step();
        end
        run = 1'b0;
        seed_valid = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            tick();
            check(rnd_valid == 1'b0, tag, {31'b0, rnd_valid}, 32'h0);
        end
    endtask

    task automatic drain(input string tag);
        tick(); tick();
        check(exp_q.size() == 0, tag, exp_q.size(), 32'h0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rnd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected sample"}, rnd_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(rnd_data == e, {cur_tag, " R4 R5 sample"}, rnd_data, e);
                if (rnd_data == e) n_match++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            check(1'b0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        logic [31:0] x;
        int m0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        check(rnd_valid == 1'b0, "R1 valid", {31'b0, rnd_valid}, 32'h0);
        check(rnd_data == 32'h0, "R1 data", rnd_data, 32'h0);
        quiet(2, "R1 unseeded");

        // R2/R3/R9: partial seed plus an out-of-range beat
        x = 32'h1234_5678;
        for (int i = 0; i < R - 1; i++) begin
            x = x * 32'd1812433253 + i;
            load_word(i, x);
        end
        load_word(R + 10, 32'hFFFF_FFFF);
        cur_tag = "R3";
        run = 1'b1;
        quiet(4, "R3 R9 partial seed quiet");
        run = 1'b0;
        tick();
        load_word(R - 1, 32'hA5A5_5A5A);

        // R6/R10: long back-to-back run past the storage wrap
        cur_tag = "R6 R10";
        run_steps(700, 1'b0);
        drain("R6 R10 drained");
        check(n_match >= 700, "R10 matches past wrap", n_match, 700);

        // R7: pause and resume
        cur_tag = "R7";
        quiet(3, "R7 paused quiet");
        run_steps(120, 1'b0);
        for (int k = 0; k < 15; k++) begin
            run_steps(1, 1'b0);
            quiet(1, "R7 single step gap");
        end
        drain("R7 drained");

        // R8: seed beats while running
        cur_tag = "R8";
        run_steps(60, 1'b1);
        drain("R8 drained");

        // R9: out-of-range beat while paused
        cur_tag = "R9";
        load_word(R + 50, 32'h0BAD_0BAD);
        run_steps(40, 1'b0);
        drain("R9 drained");

        // R2: full reseed in reverse order, then a new sequence
        cur_tag = "R2";
        x = 32'h0F0F_1357;
        for (int i = R - 1; i >= 0; i--) begin
            x = x * 32'd69069 + 32'd1;
            load_word(i, x);
        end
        m0 = n_match;
        run_steps(300, 1'b0);
        drain("R2 drained");
        check(n_match - m0 == 300, "R2 reseed matches", n_match - m0, 300);

        finish_run();
    end
endmodule